// File: doc/BRIEF.md
# Asynchronous Bus Write-Cycle Controller

This block is the master side of a single write transfer on an asynchronous 16-bit bus. A write request enters through a valid/ready handshake. The request carries the address, the write data, a two-bit size code and a three-bit function code. The block then steps through six half-clock phases, S0 to S5, and drives the bus control lines in a fixed order: address, function code, size and the write direction first; then the address strobe together with the byte-lane write enables; then the data; and last the data strobe. It waits for the slave to pull either of two active-low acknowledge lines. When the transfer is complete it raises a one-cycle `done` pulse.

The block runs on a single clock at twice the bus rate, so one clock period equals one half-clock phase. Even phases (S0, S2, and the first half of each wait pair) end on what would be a falling bus-clock edge. Acknowledge is sampled only at those points. If acknowledge is absent at the end of S2, the block inserts wait states one whole bus clock at a time until it sees acknowledge. All bus outputs come straight from flops.

Handshake rules: `req_ready` is high only while the block is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. While `req_ready` is low, `req_valid` has no effect and nothing is queued. A requester that is held off simply keeps `req_valid` high until the block returns to idle.

Top module: `wr_cycle_ctrl`

## Requirements
- R1: After reset the block is idle. `bus_rw_n`, `bus_as_n`, `bus_ds_n`, `bus_uwe_n` and `bus_lwe_n` are all 1, `bus_d_oe` and `done` are 0, and `req_ready` is 1.
- R2: In the clock after a request is accepted (S0), the address, function code and size are driven from the request and `bus_rw_n` is 0. Both strobes and both write enables stay high, and `bus_d_oe` is 0.
- R3: In S1, the next clock, `bus_as_n` goes low, and the selected write enables go low in the same clock.
- R4: Lane selection: size code 2'b01 means a byte. A byte to an even address (address bit 0 = 0) enables only `bus_uwe_n`. A byte to an odd address enables only `bus_lwe_n`. Every other size code enables both lanes.
- R5: `bus_d_oe` is 1 and `bus_d` carries the request data from S2 through S5.
- R6: `bus_ds_n` is low from S3 until the end of S4, and only while `bus_as_n` is low.
- R7: Each bit of `ack_n` passes through a two-flop synchroniser. Let acknowledge first be driven low during clock t after S0 (S0 is clock 0, t >= 0). The block then inserts n = ceil(t/2) whole wait clocks (2n phases) between S3 and S4. S4 therefore falls in clock 4+2n. Either acknowledge bit alone is enough.
- R8: In S5, `bus_as_n` and `bus_ds_n` are high again, while the write enables, `bus_rw_n` = 0 and the data stay driven.
- R9: In the clock after S5 the block is idle. Both write enables and `bus_rw_n` are 1, `bus_d_oe` is 0, and `done` is 1 for exactly that one clock.
- R10: `req_ready` is 0 from S0 through S5. A `req_valid` pulse in that window starts no cycle: after `done`, `bus_as_n` and `bus_rw_n` stay high.
- R11: Address, function code, size and data do not change from S0 through S5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus rate; one period is one phase |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Write address |
| req_data | input | 16 | Write data, already placed on its byte lanes |
| req_siz | input | 2 | Size code (2'b01 = byte, others = word) |
| req_fc | input | FC_W | Function code (address space) |
| ack_n | input | 2 | Active-low slave acknowledge, asynchronous |
| bus_addr | output | ADDR_W | Address bus |
| bus_fc | output | FC_W | Function code lines |
| bus_siz | output | 2 | Size lines |
| bus_rw_n | output | 1 | 1 = read/idle, 0 = write |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_ds_n | output | 1 | Data strobe, active low |
| bus_uwe_n | output | 1 | Upper byte write enable, active low |
| bus_lwe_n | output | 1 | Lower byte write enable, active low |
| bus_d | output | 16 | Write data |
| bus_d_oe | output | 1 | Data bus drive enable |
| done | output | 1 | One-clock pulse when the cycle has ended |

## Verification
The hardest thing to reach from the ports is the exact boundary where acknowledge arrives just in time, or just too late, for a sampling point. The synchroniser latency and the rule that sampling happens only on even phases make that boundary hard to hit. The bench places the acknowledge edge at every half-clock offset from S0 up to three wait clocks. It does this for every size code and for both address parities, and it alternates which acknowledge bit is used. It computes the expected wait count as ceil(t/2) and checks every output in every clock of each cycle. Some runs also pulse a second request mid-cycle to confirm that it is dropped.

// File: rtl/wr_cycle_pkg.sv
package wr_cycle_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_S0, ST_S1, ST_S2, ST_S3, ST_W0, ST_W1, ST_S4, ST_S5
  } wr_state_e;

  localparam logic [1:0] SZ_BYTE = 2'b01;
endpackage

// File: rtl/wr_ack_sync.sv
module wr_ack_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (STAGES < 2) begin : g_single
      logic [W-1:0] one_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) one_q <= RST_VAL;
        else        one_q <= din;
      end
      assign dout = one_q;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], din};
      end
      assign dout = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/wr_lane_decode.sv
module wr_lane_decode
  import wr_cycle_pkg::*;
(
  input  logic [1:0] siz,
  input  logic       a0,
  output logic       lane_hi,
  output logic       lane_lo
);
  logic is_byte;
  always_comb begin
    is_byte = (siz == SZ_BYTE);
    lane_hi = !is_byte || !a0;
    lane_lo = !is_byte ||  a0;
  end
endmodule

// File: rtl/wr_cycle_fsm.sv
module wr_cycle_fsm
  import wr_cycle_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      ack_any,
  output wr_state_e state_q,
  output wr_state_e state_nx
);
  logic seen_q;

  always_comb begin
    state_nx = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_nx = ST_S0;
      ST_S0:   state_nx = ST_S1;
      ST_S1:   state_nx = ST_S2;
      ST_S2:   state_nx = ST_S3;
      ST_S3:   state_nx = seen_q ? ST_S4 : ST_W0;
      ST_W0:   state_nx = ST_W1;
      ST_W1:   state_nx = seen_q ? ST_S4 : ST_W0;
      ST_S4:   state_nx = ST_S5;
      ST_S5:   state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      seen_q  <= 1'b0;
    end else begin
      state_q <= state_nx;
      if (state_q == ST_S2 || state_q == ST_W0) seen_q <= ack_any;
      else if (state_q == ST_IDLE)              seen_q <= 1'b0;
    end
  end
endmodule

// File: rtl/wr_cycle_ctrl.sv
module wr_cycle_ctrl
  import wr_cycle_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int FC_W        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_data,
  input  logic [1:0]        req_siz,
  input  logic [FC_W-1:0]   req_fc,
  input  logic [1:0]        ack_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [FC_W-1:0]   bus_fc,
  output logic [1:0]        bus_siz,
  output logic              bus_rw_n,
  output logic              bus_as_n,
  output logic              bus_ds_n,
  output logic              bus_uwe_n,
  output logic              bus_lwe_n,
  output logic [15:0]       bus_d,
  output logic              bus_d_oe,
  output logic              done
);
  localparam int ACK_W = 2;

  wr_state_e          state_q, state_nx;
  logic [ACK_W-1:0]   ack_sync_n;
  logic               ack_any, start;
  logic               lane_hi, lane_lo;
  logic               nx_busy, nx_as, nx_ds, nx_we, nx_oe;

  assign req_ready = (state_q == ST_IDLE);
  assign start     = req_valid && req_ready;
  assign ack_any   = !(&ack_sync_n);

  wr_ack_sync #(.W(ACK_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ack_n), .dout(ack_sync_n)
  );

  wr_cycle_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .ack_any(ack_any),
    .state_q(state_q), .state_nx(state_nx)
  );

  wr_lane_decode u_lane (
    .siz(bus_siz), .a0(bus_addr[0]), .lane_hi(lane_hi), .lane_lo(lane_lo)
  );

  always_comb begin
    nx_busy = (state_nx != ST_IDLE);
    nx_as   = state_nx inside {ST_S1, ST_S2, ST_S3, ST_W0, ST_W1, ST_S4};
    nx_ds   = state_nx inside {ST_S3, ST_W0, ST_W1, ST_S4};
    nx_we   = nx_as || (state_nx == ST_S5);
    nx_oe   = state_nx inside {ST_S2, ST_S3, ST_W0, ST_W1, ST_S4, ST_S5};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_addr  <= '0;
      bus_fc    <= '0;
      bus_siz   <= '0;
      bus_d     <= '0;
      bus_rw_n  <= 1'b1;
      bus_as_n  <= 1'b1;
      bus_ds_n  <= 1'b1;
      bus_uwe_n <= 1'b1;
      bus_lwe_n <= 1'b1;
      bus_d_oe  <= 1'b0;
      done      <= 1'b0;
    end else begin
      if (start) begin
        bus_addr <= req_addr;
        bus_fc   <= req_fc;
        bus_siz  <= req_siz;
        bus_d    <= req_data;
      end
      bus_rw_n  <= !nx_busy;
      bus_as_n  <= !nx_as;
      bus_ds_n  <= !nx_ds;
      bus_uwe_n <= !(nx_we && lane_hi);
      bus_lwe_n <= !(nx_we && lane_lo);
      bus_d_oe  <= nx_oe;
      done      <= (state_q == ST_S5);
    end
  end
endmodule

// File: rtl/wr_cycle_ctrl_chk.sv
module wr_cycle_ctrl_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_siz,
  input logic              bus_rw_n,
  input logic              bus_as_n,
  input logic              bus_ds_n,
  input logic              bus_uwe_n,
  input logic              bus_lwe_n,
  input logic              bus_d_oe,
  input logic              done
);
  // R6
  ds_within_as_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ds_n |-> !bus_as_n);
  // R5
  ds_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ds_n |-> bus_d_oe);
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3
  as_after_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_as_n) |-> $past(!bus_rw_n));
  // R8
  we_held_past_as_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_as_n) |-> (!bus_uwe_n || !bus_lwe_n));
  // R4
  byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_uwe_n && !bus_lwe_n) |-> (bus_siz != 2'b01));
  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rw_n && $past(!bus_rw_n)) |-> $stable(bus_addr));
  // R10
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rw_n |-> !req_ready);
endmodule

bind wr_cycle_ctrl wr_cycle_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .bus_addr(bus_addr),
  .bus_siz(bus_siz), .bus_rw_n(bus_rw_n), .bus_as_n(bus_as_n),
  .bus_ds_n(bus_ds_n), .bus_uwe_n(bus_uwe_n), .bus_lwe_n(bus_lwe_n),
  .bus_d_oe(bus_d_oe), .done(done)
);

// File: tb/wr_cycle_ctrl_tb.sv
`timescale 1ns/1ps
module wr_cycle_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic [1:0]  req_siz = '0;
  logic [2:0]  req_fc = '0;
  logic [1:0]  ack_n = 2'b11;
  logic [31:0] bus_addr;
  logic [2:0]  bus_fc;
  logic [1:0]  bus_siz;
  logic        bus_rw_n, bus_as_n, bus_ds_n, bus_uwe_n, bus_lwe_n, bus_d_oe, done;
  logic [15:0] bus_d;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  wr_cycle_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_siz(req_siz), .req_fc(req_fc),
    .ack_n(ack_n), .bus_addr(bus_addr), .bus_fc(bus_fc), .bus_siz(bus_siz),
    .bus_rw_n(bus_rw_n), .bus_as_n(bus_as_n), .bus_ds_n(bus_ds_n),
    .bus_uwe_n(bus_uwe_n), .bus_lwe_n(bus_lwe_n), .bus_d(bus_d),
    .bus_d_oe(bus_d_oe), .done(done)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [6:0] ctl_vec();
    return {bus_rw_n, bus_as_n, bus_ds_n, bus_uwe_n, bus_lwe_n, bus_d_oe, done};
  endfunction

  task automatic run_cycle(input int t, input logic [1:0] siz, input logic a0, input bit poke);
    int n2, last;
    logic [31:0] a;
    logic [15:0] d;
    logic [2:0] fc;
    logic ex_hi, ex_lo, byte_w;
    logic [6:0] ev;
    string tag;
    n2 = 2 * ((t + 1) / 2);
    last = 6 + n2;
    a = 32'h4000_0000 + 32'(t) * 32'h100 + 32'(siz) * 32'h10 + 32'(a0);
    d = 16'hA500 ^ 16'(t * 37 + siz * 5 + a0);
    fc = 3'(t + siz);
    byte_w = (siz == 2'b01);
    ex_hi = !byte_w || !a0;
    ex_lo = !byte_w || a0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d; req_siz = siz; req_fc = fc;
    @(posedge clk);
    for (int k = 0; k <= last; k++) begin
      @(negedge clk);
      if (k == 0) req_valid = 1'b0;
      if (k == t) ack_n = t[0] ? 2'b10 : 2'b01;
      if (poke && k == 2) begin req_valid = 1'b1; req_addr = ~a; end
      if (poke && k == 3) req_valid = 1'b0;
      ev[6] = !(k <= 5 + n2);
      ev[5] = !(k >= 1 && k <= 4 + n2);
      ev[4] = !(k >= 3 && k <= 4 + n2);
      ev[3] = !(k >= 1 && k <= 5 + n2 && ex_hi);
      ev[2] = !(k >= 1 && k <= 5 + n2 && ex_lo);
      ev[1] = (k >= 2 && k <= 5 + n2);
      ev[0] = (k == last);
      if (k == 0)            tag = "R2 S0 controls";
      else if (k == 1)       tag = "R3/R4 S1 strobe and lanes";
      else if (k == 2)       tag = "R5 S2 data drive";
      else if (k <= 3 + n2)  tag = "R7 wait insertion";
      else if (k == 4 + n2)  tag = "R6 S4 data strobe";
      else if (k == 5 + n2)  tag = "R8 S5 hold";
      else                   tag = "R9 return to idle";
      chk(tag, 64'(ctl_vec()), 64'(ev));
      if (k <= 5 + n2) begin
        chk("R11 addr/fc/siz held", {bus_addr, 27'(bus_fc), bus_siz, 3'b0},
            {a, 27'(fc), siz, 3'b0});
        if (k >= 2) chk("R5 data value", 64'(bus_d), 64'(d));
        if (poke) chk("R10 not ready while busy", 64'(req_ready), 64'd0);
      end
    end
    ack_n = 2'b11;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (poke) chk("R10 dropped request starts nothing", {62'd0, bus_as_n, bus_rw_n}, 64'd3);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset controls", 64'(ctl_vec()), 64'(7'b1111100));
    chk("R1 reset ready", 64'(req_ready), 64'd1);
    for (int t = 0; t <= 6; t++)
      for (int s = 0; s < 4; s++)
        for (int p = 0; p < 2; p++)
          run_cycle(t, 2'(s), p[0], (t + s + p) % 3 == 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule